// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the state sequencer of an on-chip debug unit. It moves between State1, State2, State3 and a Final state in response to four comparator match channels. An arm input starts a run. The run begins in State1. A 4-bit steering code in a small register decides how the match channels lead the sequencer out of State1. Some codes send every match to one target. Some react to a single channel. Others send two channels to different targets. When two channels fire in the same cycle, a fixed priority picks the winner.

In State2 and State3, any enabled match moves the sequencer to Final. Final is held until the unit is disarmed. Software loads the steering code only while the unit is disarmed. The state, and a flag that marks Final, are visible at the outputs on every cycle.

Top module: `dbg_seq_top`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `final_o` is 0 and `reg_rdata_o` reads 0x00.
- R2: With `arm_i` low, a write strobe loads `reg_wdata_i[3:0]` into the steering code. `reg_rdata_o` returns the code in bits 3:0 and zeros in bits 7:4, from the cycle after the write onward.
- R3: A write strobe while `arm_i` is high leaves the steering code unchanged.
- R4: `state_o` encodes idle=0, State1=1, State2=2, State3=3, Final=4. With `arm_i` high in idle, the next state is State1. With `arm_i` low, the next state is idle and `final_o` is 0.
- R5: In State1, steering codes 0, 1 and 2 send a match on any channel to State2, State3 and Final respectively.
- R6: In State1, steering codes 3, 4 and 5 send a match on channel 2 to State2, State3 and Final respectively. Matches on other channels cause no transition.
- R7: In State1, steering codes 6 to 11 route two channels each, as (channel to State2 or Final, channel to State3): 6: ch0 to State2, ch1 to State3. 7: ch0 to Final, ch1 to State3. 8: ch0 to State2, ch2 to State3. 9: ch0 to Final, ch2 to State3. 10: ch1 to State2, ch3 to State3. 11: ch1 to Final, ch3 to State3. Channels not named cause no transition.
- R8: Steering code 12 sends channels 0, 1 or 2 to State2 and ignores channel 3. Codes 13, 14 and 15 cause no transition from State1.
- R9: When several routed matches arrive in the same cycle, a match whose target is Final wins. Otherwise the lowest-numbered channel wins.
- R10: A match on channel i counts only when bit i of `match_en_i` is set.
- R11: In State2 or State3, any enabled match moves the sequencer to Final on the next cycle. Final, with `final_o` high, is held for as long as `arm_i` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Arm level; low returns the sequencer to idle |
| reg_we_i | input | 1 | Steering register write strobe |
| reg_wdata_i | input | 8 | Write data; bits 3:0 are used |
| reg_rdata_o | output | 8 | Steering register read value |
| match_i | input | 4 | Comparator match pulses, one per channel |
| match_en_i | input | 4 | Per-channel comparator enable |
| state_o | output | 3 | Current sequencer state |
| final_o | output | 1 | High while in Final |

## Verification
A wrong decode or priority choice shows up on `state_o` one clock after the match cycle, as the wrong target state. The error is never masked later, because each state is held until a further enabled match arrives or the unit is disarmed. A corrupted steering code shows up at once on `reg_rdata_o`, and again as wrong routing in the next armed run. A stuck Final or idle state is visible at `final_o` and `state_o` one cycle after an arm or disarm.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  localparam int NUM_CH = 4;
  localparam int SC_W   = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ONE   = 3'd1,
    ST_TWO   = 3'd2,
    ST_THREE = 3'd3,
    ST_FINAL = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_TWO   = 2'd1,
    TGT_THREE = 2'd2,
    TGT_FINAL = 2'd3
  } tgt_e;

  // target of one channel for a given State1 steering code
  function automatic tgt_e route_of(logic [SC_W-1:0] sc, int ch);
    tgt_e t;
    t = TGT_NONE;
    unique case (sc)
      4'd0:  t = TGT_TWO;
      4'd1:  t = TGT_THREE;
      4'd2:  t = TGT_FINAL;
      4'd3:  if (ch == 2) t = TGT_TWO;
      4'd4:  if (ch == 2) t = TGT_THREE;
      4'd5:  if (ch == 2) t = TGT_FINAL;
      4'd6:  if (ch == 0) t = TGT_TWO;   else if (ch == 1) t = TGT_THREE;
      4'd7:  if (ch == 0) t = TGT_FINAL; else if (ch == 1) t = TGT_THREE;
      4'd8:  if (ch == 0) t = TGT_TWO;   else if (ch == 2) t = TGT_THREE;
      4'd9:  if (ch == 0) t = TGT_FINAL; else if (ch == 2) t = TGT_THREE;
      4'd10: if (ch == 1) t = TGT_TWO;   else if (ch == 3) t = TGT_THREE;
      4'd11: if (ch == 1) t = TGT_FINAL; else if (ch == 3) t = TGT_THREE;
      4'd12: if (ch != 3) t = TGT_TWO;
      default: t = TGT_NONE;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/dbg_seq_ctrl_reg.sv
module dbg_seq_ctrl_reg
  import dbg_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              armed_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [SC_W-1:0]   sc_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_W = DATA_W - SC_W;

  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             sc_q <= '0;
    else if (we_i && !armed_i) sc_q <= wdata_i[SC_W-1:0];
  end

  assign sc_o    = sc_q;
  assign rdata_o = {{PAD_W{1'b0}}, sc_q};
endmodule

// File: rtl/dbg_seq_route.sv
module dbg_seq_route
  import dbg_seq_pkg::*;
(
  input  logic [SC_W-1:0]         sc_i,
  output logic [NUM_CH-1:0][1:0]  tgt_o
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_comb tgt_o[ch] = route_of(sc_i, ch);
  end
endmodule

// File: rtl/dbg_seq_prio.sv
module dbg_seq_prio
  import dbg_seq_pkg::*;
(
  input  logic [NUM_CH-1:0]       hit_i,
  input  logic [NUM_CH-1:0][1:0]  tgt_i,
  output logic                    valid_o,
  output tgt_e                    tgt_o
);
  logic [NUM_CH-1:0] fin_hit;
  logic [NUM_CH-1:0] live_hit;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hit
    assign live_hit[ch] = hit_i[ch] && (tgt_i[ch] != TGT_NONE);
    assign fin_hit[ch]  = hit_i[ch] && (tgt_i[ch] == TGT_FINAL);
  end

  always_comb begin
    tgt_o   = TGT_NONE;
    valid_o = |live_hit;
    if (|fin_hit) begin
      tgt_o = TGT_FINAL;
    end else begin
      // scan downward so the lowest channel is written last
      for (int ch = NUM_CH - 1; ch >= 0; ch--) begin
        if (live_hit[ch]) tgt_o = tgt_e'(tgt_i[ch]);
      end
    end
  end
endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
  import dbg_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic       s1_valid_i,
  input  tgt_e       s1_tgt_i,
  input  logic       any_hit_i,
  output seq_state_e state_o,
  output logic       final_o
);
  seq_state_e state_q, state_d;
  logic       final_q;

  always_comb begin
    state_d = state_q;
    if (!arm_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_ONE;
        ST_ONE: if (s1_valid_i) begin
          unique case (s1_tgt_i)
            TGT_TWO:   state_d = ST_TWO;
            TGT_THREE: state_d = ST_THREE;
            TGT_FINAL: state_d = ST_FINAL;
            default:   state_d = ST_ONE;
          endcase
        end
        ST_TWO, ST_THREE: if (any_hit_i) state_d = ST_FINAL;
        ST_FINAL: state_d = ST_FINAL;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      final_q <= 1'b0;
    end else begin
      state_q <= state_d;
      final_q <= (state_d == ST_FINAL);
    end
  end

  assign state_o = state_q;
  assign final_o = final_q;
endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
  import dbg_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [NUM_CH-1:0] match_i,
  input  logic [NUM_CH-1:0] match_en_i,
  output logic [2:0]        state_o,
  output logic              final_o
);
  logic [SC_W-1:0]        sc;
  logic [NUM_CH-1:0][1:0] tgt;
  logic [NUM_CH-1:0]      hit;
  logic                   s1_valid;
  tgt_e                   s1_tgt;
  seq_state_e             state;

  assign hit = match_i & match_en_i;

  dbg_seq_ctrl_reg #(.DATA_W(DATA_W)) ctrl_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .armed_i (arm_i),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .sc_o    (sc),
    .rdata_o (reg_rdata_o)
  );

  dbg_seq_route route_i (
    .sc_i  (sc),
    .tgt_o (tgt)
  );

  dbg_seq_prio prio_i (
    .hit_i   (hit),
    .tgt_i   (tgt),
    .valid_o (s1_valid),
    .tgt_o   (s1_tgt)
  );

  dbg_seq_fsm fsm_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm_i),
    .s1_valid_i (s1_valid),
    .s1_tgt_i   (s1_tgt),
    .any_hit_i  (|hit),
    .state_o    (state),
    .final_o    (final_o)
  );

  assign state_o = state;
endmodule

// File: rtl/dbg_seq_checker.sv
module dbg_seq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       arm_i,
  input logic [7:0] reg_rdata_o,
  input logic [3:0] match_i,
  input logic [3:0] match_en_i,
  input logic [2:0] state_o,
  input logic       final_o
);
  assert_disarm_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (state_o == 3'd0) && !final_o);

  assert_arm_to_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && state_o == 3'd0) |=> state_o == 3'd1);

  assert_armed_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> $stable(reg_rdata_o));

  assert_reserved_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && state_o == 3'd1 && reg_rdata_o[3:0] >= 4'd13) |=> state_o == 3'd1);

  assert_masked_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && state_o == 3'd1 && (match_i & match_en_i) == 4'd0) |=> state_o == 3'd1);

  assert_mid_to_final_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && (state_o == 3'd2 || state_o == 3'd3) && |(match_i & match_en_i))
      |=> final_o && state_o == 3'd4);

  assert_final_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (final_o && arm_i) |=> final_o);
endmodule

bind dbg_seq_top dbg_seq_checker chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .arm_i       (arm_i),
  .reg_rdata_o (reg_rdata_o),
  .match_i     (match_i),
  .match_en_i  (match_en_i),
  .state_o     (state_o),
  .final_o     (final_o)
);

// File: tb/dbg_seq_top_tb_top.sv
`timescale 1ns/1ps
module dbg_seq_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       arm_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [3:0] match_i = '0;
  logic [3:0] match_en_i = '0;
  logic [2:0] state_o;
  logic       final_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dbg_seq_top dut_i (.*);

  // expected State1 successor for code sc and effective match vector m
  function automatic logic [2:0] exp_s1(logic [3:0] sc, logic [3:0] m);
    case (sc)
      4'd0:  return (m != 0) ? 3'd2 : 3'd1;
      4'd1:  return (m != 0) ? 3'd3 : 3'd1;
      4'd2:  return (m != 0) ? 3'd4 : 3'd1;
      4'd3:  return m[2] ? 3'd2 : 3'd1;
      4'd4:  return m[2] ? 3'd3 : 3'd1;
      4'd5:  return m[2] ? 3'd4 : 3'd1;
      4'd6:  return m[0] ? 3'd2 : (m[1] ? 3'd3 : 3'd1);
      4'd7:  return m[0] ? 3'd4 : (m[1] ? 3'd3 : 3'd1);
      4'd8:  return m[0] ? 3'd2 : (m[2] ? 3'd3 : 3'd1);
      4'd9:  return m[0] ? 3'd4 : (m[2] ? 3'd3 : 3'd1);
      4'd10: return m[1] ? 3'd2 : (m[3] ? 3'd3 : 3'd1);
      4'd11: return m[1] ? 3'd4 : (m[3] ? 3'd3 : 3'd1);
      4'd12: return (m[2:0] != 0) ? 3'd2 : 3'd1;
      default: return 3'd1;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] sc, logic [3:0] m);
    if (m == 0) return "R10";
    if ($countones(m) > 1 && sc >= 4'd6 && sc <= 4'd12) return "R9";
    if (sc <= 4'd2) return "R5";
    if (sc <= 4'd5) return "R6";
    if (sc <= 4'd11) return "R7";
    return "R8";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic write_reg(input logic [7:0] v);
    reg_we_i = 1'b1; reg_wdata_i = v;
    tick();
    reg_we_i = 1'b0;
  endtask

  // one armed run from State1 with a given code and match pattern
  task automatic run_one(input logic [3:0] sc, input logic [3:0] m, input logic [3:0] en,
                         input logic [3:0] m2, input logic [3:0] en2);
    logic [2:0] e;
    arm_i = 1'b0; write_reg({4'hA, sc});
    chk("R2", reg_rdata_o, {4'h0, sc});
    arm_i = 1'b1; tick();
    chk("R4", state_o, 3'd1);
    match_i = m; match_en_i = en; tick();
    match_i = '0;
    e = exp_s1(sc, m & en);
    chk(req_of(sc, m & en), state_o, e);
    chk("R11", final_o, e == 3'd4);
    if (e == 3'd2 || e == 3'd3) begin
      match_i = m2; match_en_i = en2; tick();
      match_i = '0;
      chk("R11", state_o, ((m2 & en2) != 0) ? 3'd4 : e);
    end
    write_reg(8'h0D);
    chk("R3", reg_rdata_o, {4'h0, sc});
    arm_i = 1'b0; tick();
    chk("R4", {final_o, state_o}, 4'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (2) tick();
    chk("R1", {reg_rdata_o, final_o, state_o}, 12'd0);
    rst_ni = 1'b1;
    tick();
    chk("R1", state_o, 3'd0);

    write_reg(8'hFF);
    chk("R2", reg_rdata_o, 8'h0F);

    run_one(4'd7, 4'b0011, 4'hF, 4'h0, 4'h0);   // R9 final beats lower-target
    run_one(4'd6, 4'b0011, 4'hF, 4'h0, 4'h0);   // R9 lowest channel
    run_one(4'd12, 4'b1000, 4'hF, 4'h0, 4'h0);  // R8 ch3 ignored
    run_one(4'd13, 4'b1111, 4'hF, 4'h0, 4'h0);  // R8 reserved
    run_one(4'd15, 4'b1111, 4'hF, 4'h0, 4'h0);  // R8 reserved
    run_one(4'd0, 4'b1111, 4'h0, 4'h0, 4'h0);   // R10 all masked
    run_one(4'd4, 4'b1011, 4'hF, 4'h0, 4'h0);   // R6 non-ch2 ignored
    run_one(4'd11, 4'b1010, 4'hF, 4'h1, 4'h1);  // R7/R9
    run_one(4'd1, 4'b0100, 4'hF, 4'h2, 4'hD);   // R11 masked in State3

    // R11: Final held while armed, despite further traffic
    arm_i = 1'b0; write_reg(8'h02);
    arm_i = 1'b1; tick();
    match_i = 4'h8; match_en_i = 4'hF; tick();
    match_i = 4'h0;
    for (int i = 0; i < 4; i++) begin
      match_i = 4'($urandom); tick();
      chk("R11", {final_o, state_o}, {1'b1, 3'd4});
    end
    match_i = '0; arm_i = 1'b0; tick();
    chk("R4", {final_o, state_o}, 4'd0);

    for (int n = 0; n < 400; n++) begin
      run_one(4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule